// File: doc/BRIEF.md
# Load/Store Address Generation and Cache Request Unit

This block takes memory operations from the issue stage, one per cycle, and turns each one into a data cache request. It adds the base register value to the sign-extended offset to form the effective address and checks that the address suits the access width. Well-aligned accesses wait in a small in-order queue, and only the oldest entry is offered to the cache. When a load's response comes back, the returned data is widened to the full register width, using zero or sign extension. The result then goes out with the destination register and the reorder-buffer slot. Misaligned accesses never reach the cache. They report an exception, with a cause code and the reorder-buffer slot, in the next cycle.

The issue side is a valid/ready stream. An operation is taken when `issue_valid_i` and `issue_ready_o` are both high at a rising edge. `issue_ready_o` is low while the queue holds its full depth of entries, and also while `stall_i` is high. The cache request is a valid/ready stream as well. Once `req_valid_o` has been raised it stays high, with every field unchanged, until `req_ready_i` takes it, even if `stall_i` rises in the meantime. Only one request is outstanding at a time, and the next one can be offered only after its response has been taken. The response is taken when `resp_valid_i` and `resp_ready_o` are both high. `resp_ready_o` is high only while a request is waiting for its response. While `stall_i` is high the queue takes no new operation and offers no new request, so its contents stay as they are.

The cache answers stores and loads alike. Load response data arrives right-aligned in `resp_data_i`. Exceptions skip the queue, so an exception can be reported while older accesses are still queued.

Top module: `lsu_agu_top`

## Requirements
- R1: The request address is the low ADDR_W bits of `rs1_i + imm_i`, taken modulo 2^XLEN. `req_data_o` is `rs2_i`. `req_store_o` is 1 for a store and 0 for a load, the same encoding as `store_i`.
- R2: `req_size_o` is {`unsigned_i`, `size_i`}. The width codes are 00 byte, 01 halfword, 10 word and 11 doubleword.
- R3: The queue holds up to DEPTH (default 4) accepted aligned accesses and issues them to the cache in acceptance order. `issue_ready_o` is low when the queue is full, even in a cycle where an entry leaves.
- R4: While `stall_i` is high, `issue_ready_o` is low and no new request is raised. A request that was raised and not yet taken in the previous cycle stays raised.
- R5: `req_valid_o` is high only when the queue is non-empty and no response is pending. A raised request holds its fields until it is taken.
- R6: A halfword with address bit 0 set, a word with bits 1:0 not zero, or a doubleword with bits 2:0 not zero is misaligned. A misaligned access is accepted but never queued or sent. In the next cycle `exc_valid_o` is 1, `exc_cause_o` is 4 for a load or 6 for a store, and `exc_rob_o` is the access's slot.
- R7: Load data is taken from the low 8, 16, 32 or 64 bits of the response, by size. It is zero-extended when the unsigned flag is 1 and sign-extended otherwise.
- R8: In the cycle after a response is taken, `done_o` is 1. `done_rob_o` and `wb_rd_o` carry the access's slot and destination, and `wb_load_o` is 1 for a load. `wb_data_o` holds the extended load data, or zero for a store.
- R9: `resp_ready_o` is high from the cycle after a request is taken until the cycle in which its response is taken.
- R10: After reset, `issue_ready_o` is 1 and `req_valid_o`, `resp_ready_o`, `done_o` and `exc_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze queue intake and new requests |
| issue_valid_i | input | 1 | Issue operation present |
| issue_ready_o | output | 1 | Unit can take an operation |
| rob_i | input | ROB_W | Reorder-buffer slot of the operation |
| rd_i | input | 5 | Destination register |
| imm_i | input | XLEN | Sign-extended address offset |
| store_i | input | 1 | 1 store, 0 load |
| size_i | input | 2 | Access width code |
| unsigned_i | input | 1 | 1 means zero-extend a load |
| rs1_i | input | XLEN | Base register value |
| rs2_i | input | XLEN | Store data |
| req_valid_o | output | 1 | Cache request valid |
| req_ready_i | input | 1 | Cache takes the request |
| req_store_o | output | 1 | Request kind, 1 store |
| req_size_o | output | 3 | {unsigned, width code} |
| req_addr_o | output | ADDR_W | Request address |
| req_data_o | output | XLEN | Store data to cache |
| resp_valid_i | input | 1 | Cache response valid |
| resp_ready_o | output | 1 | Unit takes a response |
| resp_data_i | input | XLEN | Response data, right-aligned |
| done_o | output | 1 | Access completed |
| done_rob_o | output | ROB_W | Slot of the completed access |
| wb_rd_o | output | 5 | Destination register of the completion |
| wb_load_o | output | 1 | Completion carries load data |
| wb_data_o | output | XLEN | Extended load data |
| exc_valid_o | output | 1 | Misalignment exception |
| exc_cause_o | output | 5 | Exception cause (4 load, 6 store) |
| exc_rob_o | output | ROB_W | Slot of the faulting access |

## Verification
The clash of interest puts a misaligned access being accepted in the same cycle that a response is taken. Both reports then appear together in the next cycle, on independent output groups. The final phase of the bench keeps the cache ready and raises the misalignment rate so that this overlap happens many times. The reference model predicts `exc_*` and `done_*`/`wb_*` separately on every clock, so one report cannot mask or corrupt the other. A coverage check fails the run if the overlap never happened.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int REG_W   = 5;
  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } lsu_size_e;

  localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 5'd6;
endpackage

// File: rtl/lsu_agu.sv
module lsu_agu
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic [XLEN-1:0]    base_i,
  input  logic [XLEN-1:0]    offs_i,
  input  logic [1:0]         size_i,
  input  logic               store_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               misal_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [XLEN-1:0] sum;
  logic [3:0]      bad_by_size;

  assign sum    = base_i + offs_i;
  assign addr_o = sum[ADDR_W-1:0];

  // one misalignment test per width code; code k needs low k bits clear
  for (genvar k = 0; k < 4; k++) begin : g_align
    if (k == 0) begin : g_byte
      assign bad_by_size[k] = 1'b0;
    end else begin : g_wide
      assign bad_by_size[k] = |sum[k-1:0];
    end
  end

  assign misal_o = bad_by_size[size_i];
  assign cause_o = store_i ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
endmodule

// File: rtl/lsu_fifo.sv
module lsu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 head_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;

  // R3: the producer never writes into a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R3: the consumer never reads an empty queue
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lsu_ext.sv
module lsu_ext #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic [1:0]      size_i,
  input  logic            uns_i,
  output logic [XLEN-1:0] ext_o
);
  localparam int SHW = $clog2(XLEN) + 1;

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] up;

  // move the field to the top, then shift back logically or arithmetically
  always_comb begin
    shamt = SHW'(XLEN - (8 << size_i));
    up    = raw_i << shamt;
    if (uns_i) ext_o = up >> shamt;
    else       ext_o = $unsigned($signed(up) >>> shamt);
  end
endmodule

// File: rtl/lsu_agu_top.sv
module lsu_agu_top
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32,
  parameter int ROB_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic               issue_valid_i,
  output logic               issue_ready_o,
  input  logic [ROB_W-1:0]   rob_i,
  input  logic [REG_W-1:0]   rd_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic               store_i,
  input  logic [1:0]         size_i,
  input  logic               unsigned_i,
  input  logic [XLEN-1:0]    rs1_i,
  input  logic [XLEN-1:0]    rs2_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic               req_store_o,
  output logic [2:0]         req_size_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [XLEN-1:0]    req_data_o,
  input  logic               resp_valid_i,
  output logic               resp_ready_o,
  input  logic [XLEN-1:0]    resp_data_i,
  output logic               done_o,
  output logic [ROB_W-1:0]   done_rob_o,
  output logic [REG_W-1:0]   wb_rd_o,
  output logic               wb_load_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [ROB_W-1:0]   exc_rob_o
);
  typedef struct packed {
    logic [ROB_W-1:0]  rob;
    logic [REG_W-1:0]  rd;
    logic              store;
    logic              uns;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [XLEN-1:0]   data;
  } lsu_ent_t;

  localparam int ENT_W = $bits(lsu_ent_t);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0]  ea;
  logic               misal;
  logic [CAUSE_W-1:0] cause;
  lsu_ent_t           new_ent, head, infl_q;
  logic [ENT_W-1:0]   head_bits;
  logic               full, empty;
  logic [CNT_W-1:0]   q_count;
  logic               accept, push, req_fire, resp_fire;
  logic               busy_q, hold_q;
  logic [XLEN-1:0]    ext_data;

  lsu_agu #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_agu (
    .base_i  (rs1_i),
    .offs_i  (imm_i),
    .size_i  (size_i),
    .store_i (store_i),
    .addr_o  (ea),
    .misal_o (misal),
    .cause_o (cause)
  );

  always_comb begin
    new_ent.rob   = rob_i;
    new_ent.rd    = rd_i;
    new_ent.store = store_i;
    new_ent.uns   = unsigned_i;
    new_ent.size  = size_i;
    new_ent.addr  = ea;
    new_ent.data  = rs2_i;
  end

  assign issue_ready_o = !full && !stall_i;
  assign accept        = issue_valid_i && issue_ready_o;
  assign push          = accept && !misal;

  lsu_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .din_i   (new_ent),
    .pop_i   (req_fire),
    .head_o  (head_bits),
    .full_o  (full),
    .empty_o (empty),
    .count_o (q_count)
  );
  assign head = lsu_ent_t'(head_bits);

  // a request already on the wire survives a stall; a fresh one waits
  assign req_valid_o = !empty && !busy_q && (!stall_i || hold_q);
  assign req_fire    = req_valid_o && req_ready_i;
  assign req_store_o = head.store;
  assign req_size_o  = {head.uns, head.size};
  assign req_addr_o  = head.addr;
  assign req_data_o  = head.data;

  assign resp_ready_o = busy_q;
  assign resp_fire    = resp_valid_i && busy_q;

  lsu_ext #(.XLEN(XLEN)) u_ext (
    .raw_i  (resp_data_i),
    .size_i (infl_q.size),
    .uns_i  (infl_q.uns),
    .ext_o  (ext_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      hold_q      <= 1'b0;
      infl_q      <= '0;
      done_o      <= 1'b0;
      done_rob_o  <= '0;
      wb_rd_o     <= '0;
      wb_load_o   <= 1'b0;
      wb_data_o   <= '0;
      exc_valid_o <= 1'b0;
      exc_cause_o <= '0;
      exc_rob_o   <= '0;
    end else begin
      hold_q <= req_valid_o && !req_ready_i;
      if (req_fire) begin
        busy_q <= 1'b1;
        infl_q <= head;
      end else if (resp_fire) begin
        busy_q <= 1'b0;
      end
      done_o <= resp_fire;
      if (resp_fire) begin
        done_rob_o <= infl_q.rob;
        wb_rd_o    <= infl_q.rd;
        wb_load_o  <= !infl_q.store;
        wb_data_o  <= infl_q.store ? '0 : ext_data;
      end
      exc_valid_o <= accept && misal;
      if (accept && misal) begin
        exc_cause_o <= cause;
        exc_rob_o   <= rob_i;
      end
    end
  end

  // R5: an untaken request keeps its contents
  a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
                                    && $stable(req_data_o) && $stable(req_size_o));
  // R9: response readiness starts only after a request was taken
  a_r9_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_ready_o) |-> $past(req_valid_o && req_ready_i));
  // R8: a completion follows a taken response
  a_r8_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(resp_valid_i && resp_ready_o));
  // R6: only the two misalignment causes appear
  a_r6_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> (exc_cause_o == CAUSE_LD_MISALIGN || exc_cause_o == CAUSE_ST_MISALIGN));
  // R6: a faulting access leaves the queue occupancy untouched
  a_r6_fault_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    accept && misal && !req_fire |=> $stable(q_count));
  // R4: under stall with no departure the queue occupancy is frozen
  a_r4_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i && !req_fire |=> $stable(q_count));
endmodule

// File: tb/lsu_agu_top_tb_top.sv
`timescale 1ns/100ps
module lsu_agu_top_tb_top;
  localparam int XLEN = 64, ADDR_W = 32, ROB_W = 4, DEPTH = 4;
  localparam int NCYC = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall_i = 0, issue_valid_i = 0, store_i = 0, unsigned_i = 0;
  logic [ROB_W-1:0] rob_i = 0;
  logic [4:0] rd_i = 0;
  logic [1:0] size_i = 0;
  logic [XLEN-1:0] imm_i = 0, rs1_i = 0, rs2_i = 0, resp_data_i = 0;
  logic req_ready_i = 0, resp_valid_i = 0;
  logic issue_ready_o, req_valid_o, req_store_o, resp_ready_o;
  logic [2:0] req_size_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [XLEN-1:0] req_data_o, wb_data_o;
  logic done_o, wb_load_o, exc_valid_o;
  logic [ROB_W-1:0] done_rob_o, exc_rob_o;
  logic [4:0] wb_rd_o, exc_cause_o;

  always #2 clk = ~clk;

  lsu_agu_top #(.XLEN(XLEN), .ADDR_W(ADDR_W), .ROB_W(ROB_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .issue_valid_i(issue_valid_i),
    .issue_ready_o(issue_ready_o), .rob_i(rob_i), .rd_i(rd_i), .imm_i(imm_i),
    .store_i(store_i), .size_i(size_i), .unsigned_i(unsigned_i), .rs1_i(rs1_i),
    .rs2_i(rs2_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_store_o(req_store_o), .req_size_o(req_size_o), .req_addr_o(req_addr_o),
    .req_data_o(req_data_o), .resp_valid_i(resp_valid_i), .resp_ready_o(resp_ready_o),
    .resp_data_i(resp_data_i), .done_o(done_o), .done_rob_o(done_rob_o),
    .wb_rd_o(wb_rd_o), .wb_load_o(wb_load_o), .wb_data_o(wb_data_o),
    .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .exc_rob_o(exc_rob_o)
  );

  typedef struct {
    logic [ROB_W-1:0] rob; logic [4:0] rd; logic st; logic uns;
    logic [1:0] sz; logic [ADDR_W-1:0] addr; logic [XLEN-1:0] data;
  } op_t;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  op_t mq[$];
  op_t infl;
  bit m_busy = 0, m_hold = 0;
  bit m_done = 0, m_ld = 0, m_exc = 0;
  logic [ROB_W-1:0] m_drob, m_erob;
  logic [4:0] m_drd, m_ecause;
  logic [XLEN-1:0] m_ddata;
  int saw_full = 0, saw_stall_hold = 0, saw_clash = 0, saw_sload = 0, saw_uload = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic logic [XLEN-1:0] widen(logic [XLEN-1:0] d, logic [1:0] sz, logic uns);
    logic [XLEN-1:0] r;
    case (sz)
      2'd0: r = uns ? {56'd0, d[7:0]}  : {{56{d[7]}},  d[7:0]};
      2'd1: r = uns ? {48'd0, d[15:0]} : {{48{d[15]}}, d[15:0]};
      2'd2: r = uns ? {32'd0, d[31:0]} : {{32{d[31]}}, d[31:0]};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic bit is_misal(logic [ADDR_W-1:0] a, logic [1:0] sz);
    int al = 1 << sz;
    return (a % al) != 0;
  endfunction

  task automatic drive(int cyc);
    int pv, pr, prs, pst, pmis;
    logic [XLEN-1:0] sum;
    int al, low;
    if (cyc < 1500)      begin pv = 60; pr = 50; prs = 40; pst = 10; pmis = 25; end
    else if (cyc < 1800) begin pv = 80; pr = 5;  prs = 50; pst = 0;  pmis = 10; end
    else                 begin pv = 85; pr = 100; prs = 55; pst = 5; pmis = 45; end
    issue_valid_i = ($urandom % 100) < pv;
    req_ready_i   = ($urandom % 100) < pr;
    resp_valid_i  = ($urandom % 100) < prs;
    stall_i       = ($urandom % 100) < pst;
    rob_i = ROB_W'($urandom);
    rd_i = 5'($urandom);
    store_i = $urandom % 2;
    unsigned_i = $urandom % 2;
    size_i = 2'($urandom);
    imm_i = {$urandom, $urandom};
    rs1_i = {$urandom, $urandom};
    rs2_i = {$urandom, $urandom};
    resp_data_i = {$urandom, $urandom};
    al = 1 << size_i;
    low = ($urandom % (8 / al)) * al;
    if (size_i != 0 && ($urandom % 100) < pmis) low = low + 1;
    sum = rs1_i + imm_i;
    rs1_i = rs1_i - XLEN'(sum[2:0]) + XLEN'(low);
  endtask

  task automatic compare();
    bit full = (mq.size() == DEPTH);
    bit e_rdy = !full && !stall_i;
    bit e_req = (mq.size() > 0) && !m_busy && (!stall_i || m_hold);
    string tg = stall_i ? "R4" : "R3";
    chk(tg, "issue_ready", issue_ready_o, e_rdy);
    chk(stall_i ? "R4" : "R5", "req_valid", req_valid_o, e_req);
    if (e_req && req_valid_o) begin
      chk("R1", "req_addr", req_addr_o, mq[0].addr);
      chk("R1", "req_data", req_data_o, mq[0].data);
      chk("R1", "req_store", req_store_o, mq[0].st);
      chk("R2", "req_size", req_size_o, {mq[0].uns, mq[0].sz});
    end
    chk("R9", "resp_ready", resp_ready_o, m_busy);
    chk("R8", "done", done_o, m_done);
    if (m_done) begin
      chk("R8", "done_rob", done_rob_o, m_drob);
      chk("R8", "wb_rd", wb_rd_o, m_drd);
      chk("R8", "wb_load", wb_load_o, m_ld);
      chk(m_ld ? "R7" : "R8", "wb_data", wb_data_o, m_ddata);
    end
    chk("R6", "exc_valid", exc_valid_o, m_exc);
    if (m_exc) begin
      chk("R6", "exc_cause", exc_cause_o, m_ecause);
      chk("R6", "exc_rob", exc_rob_o, m_erob);
    end
    if (full) saw_full++;
    if (stall_i && m_hold && e_req) saw_stall_hold++;
    if (m_done && m_exc) saw_clash++;
  endtask

  task automatic step_model();
    bit e_rdy = (mq.size() != DEPTH) && !stall_i;
    bit e_req = (mq.size() > 0) && !m_busy && (!stall_i || m_hold);
    bit acc = issue_valid_i && e_rdy;
    logic [XLEN-1:0] s = rs1_i + imm_i;
    bit mis = is_misal(s[ADDR_W-1:0], size_i);
    bit rqf = e_req && req_ready_i;
    bit rsf = resp_valid_i && m_busy;
    op_t o;
    m_exc = acc && mis;
    if (m_exc) begin m_ecause = store_i ? 5'd6 : 5'd4; m_erob = rob_i; end
    m_done = rsf;
    if (rsf) begin
      m_drob = infl.rob; m_drd = infl.rd; m_ld = !infl.st;
      m_ddata = infl.st ? '0 : widen(resp_data_i, infl.sz, infl.uns);
      if (!infl.st) begin if (infl.uns) saw_uload++; else saw_sload++; end
      m_busy = 0;
    end
    if (rqf) begin infl = mq.pop_front(); m_busy = 1; end
    if (acc && !mis) begin
      o.rob = rob_i; o.rd = rd_i; o.st = store_i; o.uns = unsigned_i;
      o.sz = size_i; o.addr = s[ADDR_W-1:0]; o.data = rs2_i;
      mq.push_back(o);
    end
    m_hold = e_req && !req_ready_i;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset issue_ready", issue_ready_o, 1);
    chk("R10", "reset req_valid", req_valid_o, 0);
    chk("R10", "reset resp_ready", resp_ready_o, 0);
    chk("R10", "reset done", done_o, 0);
    chk("R10", "reset exc_valid", exc_valid_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      drive(cyc);
      #1;
      compare();
      @(posedge clk);
      step_model();
    end
    chk("R3", "queue reached full depth", saw_full > 0, 1);
    chk("R4", "stall kept a pending request", saw_stall_hold > 0, 1);
    chk("R6", "exception together with completion", saw_clash > 0, 1);
    chk("R7", "signed loads completed", saw_sload > 0, 1);
    chk("R7", "unsigned loads completed", saw_uload > 0, 1);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule